// File: doc/BRIEF.md
# Truncated-Word Third-Order Cascaded Sigma-Delta Modulator

This block produces the per-cycle integer offset that a fractional-N divider adds to its base division ratio. It runs on the divided, reference-rate clock. It takes a static 19-bit fractional word and emits a small signed offset for each divider cycle. Over time, the offsets average to the fractional word divided by 2^19.

Inside, three first-order accumulators are cascaded. Each one hands its carry to a cancellation network and passes the upper bits of its new residue to the next stage. The stage widths shrink from 20 to 15 to 10 bits. The first stage receives the fractional word shifted left by one bit. Stage two adds the top 15 bits of the stage-one residue. Stage three adds the top 10 bits of the stage-two residue. The cancellation network combines the carries as c1[n] + (c2[n] − c2[n−1]) + (c3[n] − 2·c3[n−1] + c3[n−2]).

The result leaves through a valid/ready stream port:
- A sample is consumed on any rising edge where `out_valid` and `out_ready` are both high. Only then do the accumulators and delay registers advance and the next sample appear.
- While `out_valid` is high and `out_ready` is low, the offset and all internal state hold, and `frac_word` is not sampled.
- `out_valid` never drops once raised, except through reset.

Top module: `mash111_trunc`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every accumulator and delay register and drives `out_valid` and `out_offset` to 0. The first rising edge with `rst` low produces the first sample, regardless of `out_ready`, and that first sample is always 0.
- R2: Every offset presented while `out_valid` is high is a 4-bit two's complement value within −3..+4.
- R3: After n consumed samples, the sum of the offsets minus floor(n·F/2^19) lies within −1..+2, where F is the fractional word.
- R4: While `out_valid` is high and `out_ready` is low, `out_offset` holds its value. A change of `frac_word` during that stall has no effect on any later sample.
- R5: With F = 0, every sample is 0.
- R6: With F = 2^18, the samples after reset repeat the period 0, +2, −1, +1. This follows from stage two taking the top 15 bits of the stage-one residue and stage three taking the top 10 bits of the stage-two residue.
- R7: Once raised, `out_valid` stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided reference-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| frac_word | input | 19 | Fractional word F; sampled only when a sample is produced |
| out_valid | output | 1 | An offset sample is presented |
| out_ready | input | 1 | Consumer accepts the presented sample |
| out_offset | output | 4 | Signed offset added to the integer division ratio |

## Verification
The first sample is due at the first rising edge after reset is released. Each later sample is due at the edge on which the previous one is accepted, so no sample is ever more than one register away from a handshake. The bench decides `out_ready` and reads `out_offset` at each falling edge, and records a sample only when it is about to be accepted. This keeps every expected value tied to the handshake count and not to wall-clock cycles, including across random stalls. The cumulative-sum bound, the fixed half-scale period and the zero-input case are computed arithmetically in the bench for a sweep of fractional words, half of them under back-pressure.

// File: rtl/mash_pkg.sv
package mash_pkg;
  localparam int OFF_W   = 4;
  localparam int OFF_MIN = -3;
  localparam int OFF_MAX = 4;

  function automatic logic off_in_span(input logic [OFF_W-1:0] v);
    return ($signed(v) >= OFF_MIN) && ($signed(v) <= OFF_MAX);
  endfunction
endpackage

// File: rtl/mash_acc.sv
module mash_acc #(
  parameter int W  = 20,
  parameter int TW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [W-1:0]  addend,
  output logic          carry,
  output logic [TW-1:0] res_top
);
  logic [W-1:0] res_q;
  logic [W:0]   sum;

  always_comb sum = {1'b0, res_q} + {1'b0, addend};

  assign carry   = sum[W];
  assign res_top = sum[W-1 -: TW];

  always_ff @(posedge clk) begin
    if (rst)      res_q <= '0;
    else if (adv) res_q <= sum[W-1:0];
  end

  // R4: a stalled stage keeps its residue
  assert_res_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(res_q));

  // R3: an overflow leaves a residue below the addend (modulo wrap)
  assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (adv && carry) |=> (res_q < $past(addend)));
endmodule

// File: rtl/mash_cancel.sv
module mash_cancel
  import mash_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             c1,
  input  logic             c2,
  input  logic             c3,
  output logic [OFF_W-1:0] y
);
  logic c2_d, c3_d1, c3_d2;

  always_ff @(posedge clk) begin
    if (rst) begin
      c2_d  <= 1'b0;
      c3_d1 <= 1'b0;
      c3_d2 <= 1'b0;
    end else if (adv) begin
      c2_d  <= c2;
      c3_d1 <= c3;
      c3_d2 <= c3_d1;
    end
  end

  // modulo-16 arithmetic yields the two's complement result directly
  always_comb begin
    y = OFF_W'(c1) + OFF_W'(c2) - OFF_W'(c2_d)
      + OFF_W'(c3) - OFF_W'({c3_d1, 1'b0}) + OFF_W'(c3_d2);
  end

  // R2: the combined carries never leave -3..+4
  assert_span_R2: assert property (@(posedge clk) disable iff (rst)
    off_in_span(y));
endmodule

// File: rtl/mash111_trunc.sv
module mash111_trunc
  import mash_pkg::*;
#(
  parameter int FRAC_W = 19,
  parameter int W1     = 20,
  parameter int W2     = 15,
  parameter int W3     = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [FRAC_W-1:0]       frac_word,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OFF_W-1:0] out_offset
);
  localparam int PAD = W1 - FRAC_W;

  logic          adv;
  logic [W1-1:0] add1;
  logic [W2-1:0] add2;
  logic [W3-1:0] add3;
  logic          c1, c2, c3;
  logic          res3_unused;
  logic [OFF_W-1:0] y_next;
  logic          v_q;
  logic [OFF_W-1:0] y_q;

  assign adv = !v_q || out_ready;

  generate
    if (PAD > 0) begin : g_pad
      assign add1 = {frac_word, {PAD{1'b0}}};
    end else if (PAD == 0) begin : g_same
      assign add1 = frac_word;
    end else begin : g_trim
      assign add1 = frac_word[FRAC_W-1 -: W1];
    end
  endgenerate

  mash_acc #(.W(W1), .TW(W2)) u_st1 (
    .clk(clk), .rst(rst), .adv(adv), .addend(add1), .carry(c1), .res_top(add2));
  mash_acc #(.W(W2), .TW(W3)) u_st2 (
    .clk(clk), .rst(rst), .adv(adv), .addend(add2), .carry(c2), .res_top(add3));
  mash_acc #(.W(W3), .TW(1)) u_st3 (
    .clk(clk), .rst(rst), .adv(adv), .addend(add3), .carry(c3), .res_top(res3_unused));

  mash_cancel u_cancel (
    .clk(clk), .rst(rst), .adv(adv), .c1(c1), .c2(c2), .c3(c3), .y(y_next));

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= 1'b0;
      y_q <= '0;
    end else if (adv) begin
      v_q <= 1'b1;
      y_q <= y_next;
    end
  end

  assign out_valid  = v_q;
  assign out_offset = $signed(y_q);

  // R2: presented offsets stay inside -3..+4
  assert_out_span_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> off_in_span(y_q));

  // R4: a refused sample is held unchanged
  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_offset)));

  // R7: valid never drops without reset
  assert_valid_stays_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> out_valid);
endmodule

// File: tb/mash111_trunc_tb.sv
module mash111_trunc_tb;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [18:0]       frac_word = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic signed [3:0] out_offset;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  int cycles = 0;

  always #10 clk = ~clk;

  mash111_trunc u_dut (
    .clk(clk), .rst(rst), .frac_word(frac_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_offset(out_offset));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int half_pattern(input int k);
    case (k % 4)
      0: return 0;
      1: return 2;
      2: return -1;
      default: return 1;
    endcase
  endfunction

  task automatic run_case(input logic [18:0] f, input int nsamp, input bit stall);
    longint sum = 0;
    longint flo;
    int k = 0;
    int guard = 0;
    bit rdy;
    bit prev_stall = 1'b0;
    int prev_off = 0;
    logic [15:0] lfsr = 16'hACE1;

    @(negedge clk);
    rst = 1'b1; out_ready = 1'b0; frac_word = f;
    repeat (2) @(negedge clk);
    check(!out_valid && out_offset == 0, "R1 reset", int'(out_valid), 0);
    rst = 1'b0;
    while (k < nsamp && guard < 4 * nsamp) begin
      @(negedge clk);
      guard++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rdy = stall ? !(lfsr[0] && lfsr[3]) : 1'b1;
      check(out_valid, "R7 valid", int'(out_valid), 1);
      if (out_valid) begin
        if (prev_stall)
          check(int'(out_offset) == prev_off, "R4 hold", int'(out_offset), prev_off);
        if (rdy) begin
          sum += int'(out_offset);
          flo = (longint'(k + 1) * longint'(f)) >>> 19;
          check(out_offset >= -3 && out_offset <= 4, "R2 span", int'(out_offset), 0);
          check((sum - flo) >= -1 && (sum - flo) <= 2, "R3 sum", int'(sum), int'(flo));
          if (k == 0)
            check(out_offset == 0, "R1 first", int'(out_offset), 0);
          if (f == 0)
            check(out_offset == 0, "R5 zero", int'(out_offset), 0);
          if (f == 19'h40000)
            check(int'(out_offset) == half_pattern(k), "R6 half",
                  int'(out_offset), half_pattern(k));
          k++;
        end
      end
      prev_stall = out_valid && !rdy;
      prev_off   = int'(out_offset);
      out_ready  = rdy;
      frac_word  = (out_valid && !rdy) ? ~f : f;
    end
    check(k == nsamp, "R4 progress", k, nsamp);
  endtask

  initial begin
    int n = 0;
    logic [18:0] list [11] = '{19'h0, 19'h1, 19'hF, 19'h40000, 19'h20000, 19'h7FFFF,
                              19'h7FFFE, 19'h2AAAA, 19'h55555, 19'h12345, 19'h7FFF0};
    foreach (list[i]) begin
      run_case(list[i], 1500, n[0]);
      n++;
    end
    run_case(19'h40000, 600, 1'b1);
    run_case(19'h0, 600, 1'b1);
    for (int i = 1; i <= 12; i++) begin
      run_case(19'((i * 40503) % 524288), 1500, i[0]);
    end
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    while (cycles < 190000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      done = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule